// File: doc/BRIEF.md
# Audio Clock Ratio Auto-Detector

This block watches the frame-sync and bit-clock inputs of an audio serial port while the port runs as a clock target. It brings both inputs into a fixed-frequency reference clock domain. Over each frame it counts bit-clock rising edges and the reference cycles between consecutive frame-sync rising edges. From these two counts it classifies the bit-clock-per-frame ratio and the sample rate. Rates come in two families, one based on 48 kHz and one on 44.1 kHz. The block then checks the ratio and rate together against a matrix of supported pairs. It produces a divider-setting index that a clock generator can consume directly, so no host programming is involved. Once the same valid result has been confirmed on several frames in a row, it asserts lock.

When the port runs as a clock controller, measurement is suspended. The master clock then comes from an external strap, which selects 256 × fS or 512 × fS. The outputs report that fixed selection instead of a measured one. A frame-sync watchdog drops lock and reports a missing clock when frames stop arriving.

Top module: `audio_clk_ratio_detect`

## Requirements
- R1: `ratio_code` encodes the bit-clock rising edges counted in one frame. Counts 16, 24, 32, 48, 64, 96, 128, 192, 256, 384 and 512 map to codes 0 to 10, in that ascending order. Any other count gives code 15.
- R2: `rate_code` gives the index of the nominal rate that the measured frame period matches within ±2 %, and `fam_441` gives its family. With `fam_441` = 0, the rates 8, 16, 24, 32, 48, 96 and 192 kHz map to indices 0 to 6. With `fam_441` = 1, the rates 7.35, 14.7, 22.05, 29.4, 44.1, 88.2 and 176.4 kHz map to indices 0 to 6. A period near no nominal rate gives `rate_code` 7.
- R3: A pair whose bit clock (ratio × rate) exceeds 24.576 MHz is reserved. These are ratio codes 7 and up at rate index 6, and ratio codes 9 and up at rate index 5, in either family.
- R4: Three low-rate pairs are reserved. At 8 kHz, ratio codes 0 and 1 are reserved. At 7.35 kHz, ratio codes 0 to 2 are reserved. At 14.7 kHz, ratio code 0 is reserved.
- R5: `cfg_ok` is 1 only when the ratio code is not 15, the rate code is not 7 and the pair is not reserved. `div_idx` equals rate_code × 11 + ratio_code when `cfg_ok` is 1, and 0 otherwise.
- R6: The outputs reflect the most recently completed frame within 4 reference cycles after the frame-sync rising edge that closes it. The first frame-sync edge after reset, after a timeout or after leaving controller mode only opens a frame and produces no result.
- R7: `locked` rises when 4 consecutive frames give the same valid ratio, rate and family. An invalid frame clears `locked` and the confirmation count. A differing valid frame also clears `locked`, and it counts as the first frame of a new confirmation.
- R8: If no frame-sync rising edge arrives for 2 × (REF_HZ/7350 + 1) reference cycles, the block reports a missing clock. `no_clk` goes to 1, `locked` and `cfg_ok` go to 0, and the codes return to 15, 7 and family 0.
- R9: While `ctrl_mode` is 1, no measurement is made. `ratio_code` is 8 when `mclk_512` is 0 and 10 when it is 1. `rate_code` is 7, `cfg_ok` is 1, `locked` and `no_clk` are 0, and `div_idx` is 77 plus `mclk_512`.
- R10: After reset, `ratio_code` is 15, `rate_code` is 7, `fam_441` is 0, `cfg_ok` is 0, `locked` is 0, `no_clk` is 1 and `div_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-frequency reference clock (REF_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_in | input | 1 | Asynchronous frame-sync input |
| bclk_in | input | 1 | Asynchronous bit-clock input |
| ctrl_mode | input | 1 | 1 = port is clock controller, measurement suspended |
| mclk_512 | input | 1 | Strap: master clock is 512 × fS when 1, 256 × fS when 0 |
| ratio_code | output | 4 | Bit-clock-per-frame ratio code |
| rate_code | output | 3 | Sample-rate index within the family |
| fam_441 | output | 1 | 1 = 44.1 kHz family |
| cfg_ok | output | 1 | Ratio and rate form a supported pair |
| locked | output | 1 | Result confirmed on consecutive frames |
| no_clk | output | 1 | No frame result available / frame sync lost |
| div_idx | output | 7 | Divider-setting index for the clock generator |

## Verification
On every cycle, the assertions check the relations among outputs that must hold whatever the input clocks do. A reserved pair never reads as supported. Lock implies a supported pair and appears without a code change. A missing clock excludes lock and validity. Controller mode shows only the strap-selected result. Only the bench scenarios can show the actual classification of measured frames: the ±2 % window edges, the confirmation count for lock, the restart after a mismatch, and the timeout firing after silence. The bench covers these with directed frames and a seeded random mix of ratios and rates.

// File: rtl/audio_clk_ratio_detect.sv
module audio_clk_ratio_detect #(
  parameter int unsigned REF_HZ      = 147_456_000,
  parameter int unsigned LOCK_FRAMES = 4,
  parameter int unsigned TOL_PCT     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync_in,
  input  logic       bclk_in,
  input  logic       ctrl_mode,
  input  logic       mclk_512,
  output logic [3:0] ratio_code,
  output logic [2:0] rate_code,
  output logic       fam_441,
  output logic       cfg_ok,
  output logic       locked,
  output logic       no_clk,
  output logic [6:0] div_idx
);

  localparam int unsigned TO_CYC = 2 * (REF_HZ / 7350 + 1);
  localparam int PW = $clog2(TO_CYC + 1);
  localparam int CW = $clog2(LOCK_FRAMES + 1);
  localparam int BW = 10;
  localparam int NRATE = 14;

  function automatic int unsigned rate_hz(input int k);
    case (k)
      0: rate_hz = 8000;
      1: rate_hz = 16000;
      2: rate_hz = 24000;
      3: rate_hz = 32000;
      4: rate_hz = 48000;
      5: rate_hz = 96000;
      6: rate_hz = 192000;
      7: rate_hz = 7350;
      8: rate_hz = 14700;
      9: rate_hz = 22050;
      10: rate_hz = 29400;
      11: rate_hz = 44100;
      12: rate_hz = 88200;
      13: rate_hz = 176400;
      default: rate_hz = 1;
    endcase
  endfunction

  function automatic logic is_reserved(input logic [3:0] rt, input logic [2:0] rr, input logic fm);
    is_reserved = (rr == 3'd6 && rt >= 4'd7) ||
                  (rr == 3'd5 && rt >= 4'd9) ||
                  (!fm && rr == 3'd0 && rt <= 4'd1) ||
                  (fm && rr == 3'd0 && rt <= 4'd2) ||
                  (fm && rr == 3'd1 && rt == 4'd0);
  endfunction

  logic [2:0] fs_s, bc_s;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_s <= '0;
      bc_s <= '0;
    end else begin
      fs_s <= {fs_s[1:0], fsync_in};
      bc_s <= {bc_s[1:0], bclk_in};
    end
  end

  wire fs_rise = fs_s[1] & ~fs_s[2];
  wire bc_rise = bc_s[1] & ~bc_s[2];

  logic [PW-1:0] per_cnt;
  logic [BW-1:0] bit_cnt;
  logic          armed;
  logic [3:0]    r_ratio;
  logic [2:0]    r_rate;
  logic          r_fam, r_ok, r_noclk;
  logic [CW-1:0] hit_cnt;

  logic [3:0] m_ratio;
  logic [2:0] m_rate;
  logic       m_fam, m_ok;

  always_comb begin
    case (bit_cnt)
      10'd16:  m_ratio = 4'd0;
      10'd24:  m_ratio = 4'd1;
      10'd32:  m_ratio = 4'd2;
      10'd48:  m_ratio = 4'd3;
      10'd64:  m_ratio = 4'd4;
      10'd96:  m_ratio = 4'd5;
      10'd128: m_ratio = 4'd6;
      10'd192: m_ratio = 4'd7;
      10'd256: m_ratio = 4'd8;
      10'd384: m_ratio = 4'd9;
      10'd512: m_ratio = 4'd10;
      default: m_ratio = 4'd15;
    endcase
  end

  always_comb begin
    m_rate = 3'd7;
    m_fam  = 1'b0;
    for (int k = 0; k < NRATE; k++) begin
      if (64'(per_cnt) * 64'd100 >= 64'(REF_HZ / rate_hz(k)) * 64'(100 - TOL_PCT) &&
          64'(per_cnt) * 64'd100 <= 64'(REF_HZ / rate_hz(k)) * 64'(100 + TOL_PCT)) begin
        m_rate = 3'(k % 7);
        m_fam  = (k >= 7);
      end
    end
  end

  assign m_ok = (m_ratio != 4'd15) && (m_rate != 3'd7) && !is_reserved(m_ratio, m_rate, m_fam);

  wire meas    = armed & fs_rise;
  wire timeout = !fs_rise && (per_cnt == PW'(TO_CYC - 1));
  wire same    = r_ok && r_ratio == m_ratio && r_rate == m_rate && r_fam == m_fam;

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_mode) begin
      per_cnt <= '0;
      bit_cnt <= '0;
      armed   <= 1'b0;
      r_ratio <= 4'd15;
      r_rate  <= 3'd7;
      r_fam   <= 1'b0;
      r_ok    <= 1'b0;
      r_noclk <= 1'b1;
      hit_cnt <= '0;
    end else begin
      if (fs_rise) begin
        per_cnt <= PW'(1);
        bit_cnt <= {{(BW-1){1'b0}}, bc_rise};
        armed   <= 1'b1;
      end else begin
        if (per_cnt != PW'(TO_CYC)) per_cnt <= per_cnt + 1'b1;
        if (bc_rise && bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
      if (meas) begin
        r_ratio <= m_ratio;
        r_rate  <= m_rate;
        r_fam   <= m_fam;
        r_ok    <= m_ok;
        r_noclk <= 1'b0;
        if (!m_ok)                              hit_cnt <= '0;
        else if (!same)                         hit_cnt <= CW'(1);
        else if (hit_cnt != CW'(LOCK_FRAMES))   hit_cnt <= hit_cnt + 1'b1;
      end else if (timeout) begin
        armed   <= 1'b0;
        r_ratio <= 4'd15;
        r_rate  <= 3'd7;
        r_fam   <= 1'b0;
        r_ok    <= 1'b0;
        r_noclk <= 1'b1;
        hit_cnt <= '0;
      end
    end
  end

  assign ratio_code = ctrl_mode ? (mclk_512 ? 4'd10 : 4'd8) : r_ratio;
  assign rate_code  = ctrl_mode ? 3'd7 : r_rate;
  assign fam_441    = ctrl_mode ? 1'b0 : r_fam;
  assign cfg_ok     = ctrl_mode | r_ok;
  assign locked     = !ctrl_mode && (hit_cnt >= CW'(LOCK_FRAMES));
  assign no_clk     = !ctrl_mode && r_noclk;
  assign div_idx    = ctrl_mode ? (7'd77 + {6'd0, mclk_512}) :
                      r_ok ? (7'(r_rate) * 7'd11 + 7'(r_ratio)) : 7'd0;

endmodule

// File: rtl/audio_clk_ratio_detect_chk.sv
module audio_clk_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_mode,
  input logic       mclk_512,
  input logic [3:0] ratio_code,
  input logic [2:0] rate_code,
  input logic       fam_441,
  input logic       cfg_ok,
  input logic       locked,
  input logic       no_clk
);

  // R3
  top_rate_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && rate_code == 3'd6) |-> (ratio_code < 4'd7));

  // R3
  second_rate_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && rate_code == 3'd5) |-> (ratio_code < 4'd9));

  // R4
  low_rate_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && rate_code == 3'd0) |-> (ratio_code >= (fam_441 ? 4'd3 : 4'd2)));

  // R4
  fam441_second_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok && fam_441 && rate_code == 3'd1) |-> (ratio_code != 4'd0));

  // R7
  lock_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> cfg_ok);

  // R7
  lock_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($stable(ratio_code) && $stable(rate_code) && $stable(fam_441)));

  // R8
  no_clk_excludes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_clk |-> (!locked && !cfg_ok));

  // R9
  ctrl_mode_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_mode |-> (cfg_ok && !locked && !no_clk && rate_code == 3'd7 &&
                   ratio_code == (mclk_512 ? 4'd10 : 4'd8)));

endmodule

bind audio_clk_ratio_detect audio_clk_ratio_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .mclk_512(mclk_512),
  .ratio_code(ratio_code), .rate_code(rate_code), .fam_441(fam_441),
  .cfg_ok(cfg_ok), .locked(locked), .no_clk(no_clk)
);

// File: tb/audio_clk_ratio_detect_bench.sv
module audio_clk_ratio_detect_bench;

  localparam int unsigned REF = 147_456_000;
  localparam int TO_CYC = 2 * (REF / 7350 + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fsync_in = 1'b0, bclk_in = 1'b0, ctrl_mode = 1'b0, mclk_512 = 1'b0;
  logic [3:0] ratio_code;
  logic [2:0] rate_code;
  logic fam_441, cfg_ok, locked, no_clk;
  logic [6:0] div_idx;

  int total = 0, bad = 0;
  bit reported = 0;
  int m_cnt = 0, m_prev_ok = 0, m_prev_ratio = 0, m_prev_rate = 0, m_prev_fam = 0;

  always #5 clk = ~clk;

  audio_clk_ratio_detect #(.REF_HZ(REF)) u_audio_clk_ratio_detect (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in), .bclk_in(bclk_in),
    .ctrl_mode(ctrl_mode), .mclk_512(mclk_512), .ratio_code(ratio_code),
    .rate_code(rate_code), .fam_441(fam_441), .cfg_ok(cfg_ok), .locked(locked),
    .no_clk(no_clk), .div_idx(div_idx));

  function automatic int hz_of(input int k);
    int t [14] = '{8000, 16000, 24000, 32000, 48000, 96000, 192000,
                   7350, 14700, 22050, 29400, 44100, 88200, 176400};
    return t[k];
  endfunction

  function automatic int ratio_idx(input int n);
    int t [11] = '{16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512};
    for (int i = 0; i < 11; i++) if (t[i] == n) return i;
    return 15;
  endfunction

  function automatic int reserved(input int n, input int k);
    int hz = hz_of(k);
    if (longint'(n) * hz > 64'd24_576_000) return 1;
    if (hz == 8000 && n <= 24) return 1;
    if (hz == 7350 && n <= 32) return 1;
    if (hz == 14700 && n == 16) return 1;
    return 0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic frame(input int n, input int per);
    int base = per / n;
    int extra = per % n;
    for (int i = 0; i < n; i++) begin
      int len = base + ((i < extra) ? 1 : 0);
      if (i == n / 2) fsync_in = 1'b0;
      bclk_in = 1'b0;
      tick(len - len / 2);
      bclk_in = 1'b1;
      tick(len / 2);
    end
    bclk_in = 1'b0;
    fsync_in = 1'b1;
    tick(4);
  endtask

  task automatic restart();
    ctrl_mode = 1'b1;
    tick(2);
    ctrl_mode = 1'b0;
    fsync_in = 1'b0;
    bclk_in = 1'b0;
    tick(3);
    fsync_in = 1'b1;
    tick(4);
    m_cnt = 0;
    m_prev_ok = 0;
  endtask

  task automatic frame_and_check(input string req, input int n, input int k);
    int ri = ratio_idx(n);
    int rr = k % 7;
    int fm = (k >= 7) ? 1 : 0;
    int ok = (ri != 15 && reserved(n, k) == 0) ? 1 : 0;
    frame(n, REF / hz_of(k));
    if (!ok) m_cnt = 0;
    else if (m_prev_ok && m_prev_ratio == ri && m_prev_rate == rr && m_prev_fam == fm) m_cnt++;
    else m_cnt = 1;
    m_prev_ok = ok; m_prev_ratio = ri; m_prev_rate = rr; m_prev_fam = fm;
    chk(req, "ratio_code", int'(ratio_code), ri);
    chk(req, "rate_code", int'(rate_code), rr);
    chk(req, "fam_441", int'(fam_441), fm);
    chk(req, "cfg_ok", int'(cfg_ok), ok);
    chk(req, "div_idx", int'(div_idx), ok ? rr * 11 + ri : 0);
    chk(req, "locked", int'(locked), (m_cnt >= 4) ? 1 : 0);
    chk(req, "no_clk", int'(no_clk), 0);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int unsigned seed_init;
    int rsel [4] = '{6, 13, 5, 12};
    int lst [11] = '{16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512};
    int k, n;
    seed_init = $urandom(32'd4242);
    tick(4);
    // R10 reset state
    chk("R10", "ratio_code", int'(ratio_code), 15);
    chk("R10", "rate_code", int'(rate_code), 7);
    chk("R10", "fam_441", int'(fam_441), 0);
    chk("R10", "cfg_ok", int'(cfg_ok), 0);
    chk("R10", "locked", int'(locked), 0);
    chk("R10", "no_clk", int'(no_clk), 1);
    chk("R10", "div_idx", int'(div_idx), 0);
    rst_n = 1'b1;
    tick(2);

    // R9 controller mode
    ctrl_mode = 1'b1; mclk_512 = 1'b0;
    tick(2);
    chk("R9", "ratio_code", int'(ratio_code), 8);
    chk("R9", "div_idx", int'(div_idx), 77);
    chk("R9", "cfg_ok", int'(cfg_ok), 1);
    chk("R9", "rate_code", int'(rate_code), 7);
    chk("R9", "no_clk", int'(no_clk), 0);
    mclk_512 = 1'b1;
    tick(1);
    chk("R9", "ratio_code", int'(ratio_code), 10);
    chk("R9", "div_idx", int'(div_idx), 78);
    // R9: frames during controller mode are not measured
    frame(64, REF / 192000);
    chk("R9", "locked", int'(locked), 0);
    chk("R9", "ratio_code", int'(ratio_code), 10);

    // R6 first edge only opens a frame
    restart();
    chk("R6", "no_clk", int'(no_clk), 1);
    chk("R6", "ratio_code", int'(ratio_code), 15);

    // R7 lock after four identical frames, restart on mismatch
    for (int i = 0; i < 3; i++) frame_and_check("R7", 64, 6);
    chk("R7", "locked_before_4th", int'(locked), 0);
    frame_and_check("R7", 64, 6);
    chk("R7", "locked_at_4th", int'(locked), 1);
    frame_and_check("R7", 32, 6);
    chk("R7", "locked_after_mismatch", int'(locked), 0);
    for (int i = 0; i < 3; i++) frame_and_check("R7", 32, 6);
    chk("R7", "relocked", int'(locked), 1);
    // R1 unsupported count clears lock
    frame_and_check("R1", 40, 6);
    chk("R1", "ratio_code_40", int'(ratio_code), 15);

    // R3 ceiling
    frame_and_check("R3", 192, 6);
    frame_and_check("R3", 384, 5);
    frame_and_check("R3", 256, 5);
    frame_and_check("R3", 128, 13);
    frame_and_check("R3", 192, 13);

    // R2 window edges at 48 kHz (3072 cycles nominal)
    frame(64, 3072 * 101 / 100);
    chk("R2", "rate_in_window", int'(rate_code), 4);
    chk("R5", "div_in_window", int'(div_idx), 48);
    frame(64, 3072 * 104 / 100);
    chk("R2", "rate_out_window", int'(rate_code), 7);
    chk("R5", "cfg_out_window", int'(cfg_ok), 0);
    chk("R5", "div_out_window", int'(div_idx), 0);
    frame(64, 3072 * 985 / 1000);
    chk("R2", "rate_low_window", int'(rate_code), 4);
    m_cnt = 1; m_prev_ok = 1; m_prev_ratio = 4; m_prev_rate = 4; m_prev_fam = 0;

    // R4 low-rate reserved pairs
    frame_and_check("R4", 24, 0);
    frame_and_check("R4", 32, 7);
    frame_and_check("R4", 16, 8);
    frame_and_check("R4", 24, 8);

    // R1 R2 R5 R7 seeded random mix
    k = 6; n = 64;
    for (int i = 0; i < 24; i++) begin
      if ($urandom() % 2 == 0 || i == 0) begin
        k = rsel[$urandom() % 4];
        if ($urandom() % 8 == 0) begin
          n = 17 + int'($urandom() % 190);
          while (ratio_idx(n) != 15) n++;
        end else begin
          n = lst[$urandom() % 11];
          while ((REF / hz_of(k)) / n < 2) n = lst[$urandom() % 8];
        end
      end
      frame_and_check("R5", n, k);
    end

    // R8 timeout
    tick(TO_CYC + 10);
    chk("R8", "no_clk", int'(no_clk), 1);
    chk("R8", "locked", int'(locked), 0);
    chk("R8", "cfg_ok", int'(cfg_ok), 0);
    chk("R8", "ratio_code", int'(ratio_code), 15);
    chk("R8", "rate_code", int'(rate_code), 7);
    report();
  end

endmodule